// File: doc/BRIEF.md
# Multiplexed ADC Acquisition Sequencer

This block runs a parallel-output analog-to-digital converter that sits behind an analog multiplexer. A conversion begins either from a one-cycle command strobe or from the rising edge of a periodic trigger pin driven by a timer. The sequencer first pulses the convert line. It then waits for a completion event, which comes from an external ready pin or from an internal done pulse, as configuration selects. After that it switches the converter to read mode and drops chip-select for a programmed number of cycles. It latches the sample as chip-select rises.

Each captured sample leaves on a valid/ready stream together with the multiplexer address it was taken from. The address output is the programmed base plus a running channel index. That index advances after every capture and returns to zero after the programmed channel count. While the stream is stalled, the sample is held and no new conversion begins. A trigger edge that lands while the sequencer is busy is dropped and reported by a one-cycle overrun pulse.

Top module: `adc_acq_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `adc_cs_n_o` and `adc_rc_n_o` are 1, `m_valid_o` and `overrun_o` are 0, and `mux_addr_o` equals `cfg_start_addr_i`.
- R2: A one-cycle `cmd_start_i` taken while idle drives `adc_rc_n_o` low (convert) for exactly 1 + `cfg_wait_i` cycles, beginning in the next cycle.
- R3: A rising edge on `trig_pin_i` starts a conversion after a synchronizer of two flops plus one edge flop. Chip-select goes low no sooner than 5 + `cfg_wait_i` cycles after the edge.
- R4: With `cfg_done_sel_i` = 1, a pulse on `int_done_i` ends the conversion wait. With 0, a synchronized rising edge of `ext_ready_pin_i` ends it. The source that is not selected has no effect.
- R5: Between the completion event and chip-select falling, `adc_rc_n_o` stays high (read) and chip-select stays high for exactly 1 + `cfg_wait_i` cycles.
- R6: `adc_cs_n_o` stays low for exactly 1 + `cfg_wait_i` cycles. The value on `adc_data_i` in the last low cycle appears on `m_data_o` with `m_valid_o` in the next cycle.
- R7: `mux_addr_o` is `cfg_start_addr_i` plus the channel index, modulo 2^8. `m_chan_o` carries the address used for the sample. The index advances by one at each capture and at no other time.
- R8: After `cfg_chan_count_i` captures the index wraps to 0. A count of 0 or 1 keeps it at 0.
- R9: A trigger edge while a conversion or a held sample is in progress raises `overrun_o` for one cycle and is not queued.
- R10: While `m_valid_o` is 1 and `m_ready_i` is 0, the data and channel outputs hold and both strobes stay high. The sample is released one cycle after `m_ready_i` is seen high.
- R11: `cmd_start_i` has no effect unless the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start_i | input | 1 | Single-shot conversion request, one cycle |
| trig_pin_i | input | 1 | Asynchronous periodic trigger, acts on rising edge |
| ext_ready_pin_i | input | 1 | Asynchronous converter ready, acts on rising edge |
| int_done_i | input | 1 | Synchronous internal completion pulse |
| cfg_done_sel_i | input | 1 | Completion source: 1 internal pulse, 0 ready pin |
| cfg_start_addr_i | input | 8 | Multiplexer base address |
| cfg_chan_count_i | input | 8 | Channels in the scan (0 and 1 mean one) |
| cfg_wait_i | input | 4 | Wait-state count, 0 to 15 |
| adc_data_i | input | 16 | Converter parallel data |
| adc_cs_n_o | output | 1 | Converter chip-select, active low |
| adc_rc_n_o | output | 1 | Read (1) / convert (0) select |
| mux_addr_o | output | 8 | Current multiplexer channel address |
| overrun_o | output | 1 | One-cycle pulse on a dropped trigger |
| m_valid_o | output | 1 | Sample stream valid |
| m_ready_i | input | 1 | Sample stream ready |
| m_data_o | output | 16 | Captured sample |
| m_chan_o | output | 8 | Channel address of the sample |

## Verification
Several properties are checked on every cycle: the chip-select low width, the read-mode setup before chip-select falls, that the edge detectors give single-cycle pulses, that the channel index stays put except at a capture, and that a held sample is stable while both strobes stay quiet. Only the directed scenarios can show the rest. These are the exact convert-pulse length, the trigger-to-select latency, the blocking of the unselected completion source, the address sequence with its wrap (including the wrap from 0xFF to 0x00), and that a dropped trigger starts no later conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_SETUP,
        ST_STROBE,
        ST_OUT
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic rc_n;
    } adc_strobe_t;

    // Next scan index; a count of 0 or 1 pins the index at zero.
    function automatic logic [15:0] next_chan_index(input logic [15:0] idx,
                                                    input logic [15:0] count);
        logic [16:0] inc;
        inc = {1'b0, idx} + 17'd1;
        if (count <= 16'd1 || inc >= {1'b0, count})
            return 16'd0;
        return inc[15:0];
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] holds previous level
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-1:0], pin_i};
    end

    assign rise_o = chain[STAGES-1] & ~chain[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R3

endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W = 8   // at most 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] count_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (adv_i)
            idx_q <= ADDR_W'(next_chan_index(16'(idx_q), 16'(count_i)));
    end

    assign addr_o = start_i + idx_q;

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(idx_q)); // R7

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int WS_W     = 4,
    parameter int SAMPLE_W = 16,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_start_i,
    input  logic                trig_rise_i,
    input  logic                done_sel_i,
    input  logic                ext_done_rise_i,
    input  logic                int_done_i,
    input  logic [WS_W-1:0]     wait_i,
    input  logic [SAMPLE_W-1:0] adc_data_i,
    input  logic [ADDR_W-1:0]   chan_addr_i,
    input  logic                m_ready_i,
    output adc_strobe_t         strobe_o,
    output logic                adv_o,
    output logic                overrun_o,
    output logic                m_valid_o,
    output logic [SAMPLE_W-1:0] m_data_o,
    output logic [ADDR_W-1:0]   m_chan_o
);
    localparam int RUN_W = WS_W + 2;

    seq_state_e            state_q;
    logic [WS_W-1:0]       phase_q;
    logic [SAMPLE_W-1:0]   data_q;
    logic [ADDR_W-1:0]     chan_q;
    logic                  ovr_q;
    logic                  start_req;
    logic                  done_ev;
    logic                  phase_end;

    assign start_req = cmd_start_i | trig_rise_i;
    assign done_ev   = done_sel_i ? int_done_i : ext_done_rise_i;
    assign phase_end = (phase_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            data_q  <= '0;
            chan_q  <= '0;
            ovr_q   <= 1'b0;
        end else begin
            ovr_q <= trig_rise_i && (state_q != ST_IDLE);
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        state_q <= ST_CONV;
                        phase_q <= wait_i;
                    end
                end
                ST_CONV: begin
                    if (phase_end) state_q <= ST_WAIT;
                    else           phase_q <= phase_q - 1'b1;
                end
                ST_WAIT: begin
                    if (done_ev) begin
                        state_q <= ST_SETUP;
                        phase_q <= wait_i;
                    end
                end
                ST_SETUP: begin
                    if (phase_end) begin
                        state_q <= ST_STROBE;
                        phase_q <= wait_i;
                    end else begin
                        phase_q <= phase_q - 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (phase_end) begin
                        state_q <= ST_OUT;
                        data_q  <= adc_data_i;
                        chan_q  <= chan_addr_i;
                    end else begin
                        phase_q <= phase_q - 1'b1;
                    end
                end
                ST_OUT: begin
                    if (m_ready_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign strobe_o.cs_n = (state_q != ST_STROBE);
    assign strobe_o.rc_n = (state_q != ST_CONV);
    assign adv_o         = (state_q == ST_STROBE) && phase_end;
    assign overrun_o     = ovr_q;
    assign m_valid_o     = (state_q == ST_OUT);
    assign m_data_o      = data_q;
    assign m_chan_o      = chan_q;

    // Run-length monitors for the strobe timing checks
    logic [RUN_W-1:0] low_run_q;
    logic [RUN_W-1:0] read_run_q;
    logic [RUN_W-1:0] ws_len;
    assign ws_len = RUN_W'(wait_i) + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run_q  <= '0;
            read_run_q <= '0;
        end else begin
            if (!strobe_o.cs_n) low_run_q <= low_run_q + 1'b1;
            else                low_run_q <= '0;
            if (!strobe_o.rc_n)
                read_run_q <= '0;
            else if (strobe_o.cs_n && read_run_q != '1)
                read_run_q <= read_run_q + 1'b1;
        end
    end

    AST_CS_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_o.cs_n) |-> (low_run_q == ws_len)); // R6

    AST_READ_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_o.cs_n) |-> (read_run_q >= ws_len)); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_chan_o))); // R10

    AST_QUIET_WHEN_HELD: assert property (@(posedge clk) disable iff (rst)
        m_valid_o |-> (strobe_o.cs_n && strobe_o.rc_n)); // R10

endmodule

// File: rtl/adc_acq_seq.sv
module adc_acq_seq
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W    = 16,
    parameter int ADDR_W      = 8,
    parameter int WS_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_start_i,
    input  logic                trig_pin_i,
    input  logic                ext_ready_pin_i,
    input  logic                int_done_i,
    input  logic                cfg_done_sel_i,
    input  logic [ADDR_W-1:0]   cfg_start_addr_i,
    input  logic [ADDR_W-1:0]   cfg_chan_count_i,
    input  logic [WS_W-1:0]     cfg_wait_i,
    input  logic [SAMPLE_W-1:0] adc_data_i,
    output logic                adc_cs_n_o,
    output logic                adc_rc_n_o,
    output logic [ADDR_W-1:0]   mux_addr_o,
    output logic                overrun_o,
    output logic                m_valid_o,
    input  logic                m_ready_i,
    output logic [SAMPLE_W-1:0] m_data_o,
    output logic [ADDR_W-1:0]   m_chan_o
);
    logic        trig_rise;
    logic        ready_rise;
    logic        adv;
    adc_strobe_t strobe;

    adc_seq_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (trig_pin_i),
        .rise_o (trig_rise)
    );

    adc_seq_sync #(.STAGES(SYNC_STAGES)) u_ready_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_ready_pin_i),
        .rise_o (ready_rise)
    );

    adc_seq_chan #(.ADDR_W(ADDR_W)) u_chan (
        .clk     (clk),
        .rst     (rst),
        .start_i (cfg_start_addr_i),
        .count_i (cfg_chan_count_i),
        .adv_i   (adv),
        .addr_o  (mux_addr_o)
    );

    adc_seq_ctrl #(
        .WS_W     (WS_W),
        .SAMPLE_W (SAMPLE_W),
        .ADDR_W   (ADDR_W)
    ) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .cmd_start_i     (cmd_start_i),
        .trig_rise_i     (trig_rise),
        .done_sel_i      (cfg_done_sel_i),
        .ext_done_rise_i (ready_rise),
        .int_done_i      (int_done_i),
        .wait_i          (cfg_wait_i),
        .adc_data_i      (adc_data_i),
        .chan_addr_i     (mux_addr_o),
        .m_ready_i       (m_ready_i),
        .strobe_o        (strobe),
        .adv_o           (adv),
        .overrun_o       (overrun_o),
        .m_valid_o       (m_valid_o),
        .m_data_o        (m_data_o),
        .m_chan_o        (m_chan_o)
    );

    assign adc_cs_n_o = strobe.cs_n;
    assign adc_rc_n_o = strobe.rc_n;

endmodule

// File: tb/adc_acq_seq_tb.sv
module adc_acq_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start_i = 1'b0;
    logic        trig_pin_i = 1'b0;
    logic        ext_ready_pin_i = 1'b0;
    logic        int_done_i = 1'b0;
    logic        cfg_done_sel_i = 1'b1;
    logic [7:0]  cfg_start_addr_i = 8'h40;
    logic [7:0]  cfg_chan_count_i = 8'd3;
    logic [3:0]  cfg_wait_i = 4'd0;
    logic [15:0] adc_data_i = 16'h0;
    logic        adc_cs_n_o, adc_rc_n_o, overrun_o, m_valid_o;
    logic        m_ready_i = 1'b1;
    logic [7:0]  mux_addr_o, m_chan_o;
    logic [15:0] m_data_o;

    int checks = 0;
    int failures = 0;

    adc_acq_seq u_dut (
        .clk(clk), .rst(rst), .cmd_start_i(cmd_start_i), .trig_pin_i(trig_pin_i),
        .ext_ready_pin_i(ext_ready_pin_i), .int_done_i(int_done_i),
        .cfg_done_sel_i(cfg_done_sel_i), .cfg_start_addr_i(cfg_start_addr_i),
        .cfg_chan_count_i(cfg_chan_count_i), .cfg_wait_i(cfg_wait_i),
        .adc_data_i(adc_data_i), .adc_cs_n_o(adc_cs_n_o), .adc_rc_n_o(adc_rc_n_o),
        .mux_addr_o(mux_addr_o), .overrun_o(overrun_o), .m_valid_o(m_valid_o),
        .m_ready_i(m_ready_i), .m_data_o(m_data_o), .m_chan_o(m_chan_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] base, input logic [7:0] cnt,
                            input logic [3:0] ws, input logic sel);
        rst = 1'b1;
        cfg_start_addr_i = base;
        cfg_chan_count_i = cnt;
        cfg_wait_i = ws;
        cfg_done_sel_i = sel;
        cmd_start_i = 0; trig_pin_i = 0; ext_ready_pin_i = 0; int_done_i = 0;
        m_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_cmd();
        cmd_start_i = 1'b1;
        @(negedge clk);
        cmd_start_i = 1'b0;
    endtask

    // Waits for the convert pulse and measures its length; returns in the first wait cycle.
    task automatic wait_conv(output int rc_low);
        int guard = 0;
        while (adc_rc_n_o && guard < 100) begin @(negedge clk); guard++; end
        rc_low = 0;
        while (!adc_rc_n_o && guard < 200) begin rc_low++; @(negedge clk); guard++; end
    endtask

    // Gives completion, measures setup and strobe, drives data during strobe.
    task automatic finish_conv(input logic sel, output int setup, output int cs_low,
                               output logic [15:0] last);
        int guard = 0;
        if (sel) begin
            int_done_i = 1'b1; @(negedge clk); int_done_i = 1'b0;
        end else begin
            ext_ready_pin_i = 1'b1;
        end
        setup = 0;
        while (adc_cs_n_o && guard < 100) begin setup++; @(negedge clk); guard++; end
        ext_ready_pin_i = 1'b0;
        cs_low = 0;
        last = 16'h0;
        while (!adc_cs_n_o && guard < 200) begin
            last = 16'h1357 + 16'(cs_low * 16'h0101);
            adc_data_i = last;
            cs_low++;
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic test_reset();
        do_reset(8'h5A, 8'd3, 4'd2, 1'b1);
        check(adc_cs_n_o == 1'b1, "R1", "cs_n after reset", adc_cs_n_o, 1);
        check(adc_rc_n_o == 1'b1 && m_valid_o == 1'b0 && overrun_o == 1'b0,
              "R1", "rc_n/valid/overrun after reset",
              {adc_rc_n_o, m_valid_o, overrun_o}, 3'b100);
        check(mux_addr_o == 8'h5A, "R1", "mux address after reset", mux_addr_o, 8'h5A);
    endtask

    task automatic test_cmd_timing(input logic [3:0] ws);
        int rc_low, setup, cs_low;
        logic [15:0] last;
        do_reset(8'h10, 8'd4, ws, 1'b1);
        pulse_cmd();
        wait_conv(rc_low);
        check(rc_low == int'(ws) + 1, "R2", "convert pulse length", rc_low, int'(ws) + 1);
        finish_conv(1'b1, setup, cs_low, last);
        check(setup == int'(ws) + 1, "R5", "read setup length", setup, int'(ws) + 1);
        check(cs_low == int'(ws) + 1, "R6", "chip-select low length", cs_low, int'(ws) + 1);
        check(m_valid_o && m_data_o == last, "R6", "captured sample", m_data_o, last);
        check(m_chan_o == 8'h10, "R7", "sample channel", m_chan_o, 8'h10);
        @(negedge clk);
        check(mux_addr_o == 8'h11, "R7", "address after capture", mux_addr_o, 8'h11);
    endtask

    task automatic test_scan(input logic [7:0] base, input logic [7:0] cnt, input int n);
        int rc_low, setup, cs_low;
        logic [15:0] last;
        int exp_idx = 0;
        int lim = (cnt <= 1) ? 1 : int'(cnt);
        do_reset(base, cnt, 4'd1, 1'b1);
        for (int i = 0; i < n; i++) begin
            pulse_cmd();
            wait_conv(rc_low);
            finish_conv(1'b1, setup, cs_low, last);
            check(m_chan_o == 8'(int'(base) + exp_idx), "R8", "scan channel",
                  m_chan_o, 8'(int'(base) + exp_idx));
            exp_idx = (exp_idx + 1 >= lim) ? 0 : exp_idx + 1;
            @(negedge clk);
        end
    endtask

    task automatic test_trigger(input logic [3:0] ws);
        int cnt = 0;
        int cs_low, setup;
        logic seen_lo = 0;
        logic gave = 0;
        logic [15:0] last;
        do_reset(8'h20, 8'd2, ws, 1'b1);
        trig_pin_i = 1'b1;
        while (adc_cs_n_o && cnt < 200) begin
            @(negedge clk);
            cnt++;
            int_done_i = 1'b0;
            if (!adc_rc_n_o) seen_lo = 1'b1;
            else if (seen_lo && !gave) begin int_done_i = 1'b1; gave = 1'b1; end
        end
        int_done_i = 1'b0;
        check(cnt >= 5 + int'(ws) && cnt < 200, "R3", "trigger to chip-select cycles",
              cnt, 5 + int'(ws));
        setup = 0; cs_low = 0; last = 16'h0;
        while (!adc_cs_n_o && cs_low < 100) begin
            last = 16'hBEE0 + 16'(cs_low);
            adc_data_i = last;
            cs_low++;
            @(negedge clk);
        end
        check(m_valid_o && m_data_o == last, "R3", "triggered sample", m_data_o, last);
        trig_pin_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_done_select();
        int rc_low, setup, cs_low, moved = 0;
        logic [15:0] last;
        // ready pin selected: internal pulse must be ignored
        do_reset(8'h30, 8'd2, 4'd0, 1'b0);
        pulse_cmd();
        wait_conv(rc_low);
        int_done_i = 1'b1; @(negedge clk); int_done_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (!adc_cs_n_o || m_valid_o) moved++;
            @(negedge clk);
        end
        check(moved == 0, "R4", "internal pulse ignored in pin mode", moved, 0);
        finish_conv(1'b0, setup, cs_low, last);
        check(m_valid_o && m_data_o == last, "R4", "ready pin completes", m_data_o, last);
        // internal selected: ready pin must be ignored
        do_reset(8'h30, 8'd2, 4'd0, 1'b1);
        pulse_cmd();
        wait_conv(rc_low);
        ext_ready_pin_i = 1'b1;
        moved = 0;
        for (int i = 0; i < 8; i++) begin
            if (!adc_cs_n_o || m_valid_o) moved++;
            @(negedge clk);
        end
        ext_ready_pin_i = 1'b0;
        check(moved == 0, "R4", "ready pin ignored in internal mode", moved, 0);
        finish_conv(1'b1, setup, cs_low, last);
        check(m_valid_o, "R4", "internal pulse completes", m_valid_o, 1);
    endtask

    task automatic test_overrun();
        int rc_low, setup, cs_low, pulses = 0, starts = 0;
        logic [15:0] last;
        do_reset(8'h50, 8'd2, 4'd0, 1'b1);
        pulse_cmd();
        wait_conv(rc_low);
        trig_pin_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (overrun_o) pulses++;
        end
        check(pulses == 1, "R9", "overrun pulse count", pulses, 1);
        finish_conv(1'b1, setup, cs_low, last);
        check(m_valid_o, "R9", "busy conversion completes", m_valid_o, 1);
        trig_pin_i = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!adc_rc_n_o) starts++;
        end
        check(starts == 0, "R9", "dropped trigger not queued", starts, 0);
    endtask

    task automatic test_hold();
        int rc_low, setup, cs_low, bad = 0, starts = 0;
        logic [15:0] last;
        do_reset(8'h60, 8'd4, 4'd1, 1'b1);
        m_ready_i = 1'b0;
        pulse_cmd();
        wait_conv(rc_low);
        // R11: command during a conversion is ignored
        pulse_cmd();
        finish_conv(1'b1, setup, cs_low, last);
        for (int i = 0; i < 8; i++) begin
            if (i == 2) cmd_start_i = 1'b1;
            if (i == 3) cmd_start_i = 1'b0;
            if (!m_valid_o || m_data_o != last || m_chan_o != 8'h60) bad++;
            if (!adc_rc_n_o || !adc_cs_n_o) starts++;
            @(negedge clk);
        end
        check(bad == 0, "R10", "sample held while stalled", bad, 0);
        check(starts == 0, "R11", "no conversion while held", starts, 0);
        m_ready_i = 1'b1;
        @(negedge clk);
        check(m_valid_o == 1'b0, "R10", "released after ready", m_valid_o, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!adc_rc_n_o) starts++;
        end
        check(starts == 0, "R11", "earlier commands not remembered", starts, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        test_reset();
        test_cmd_timing(4'd0);
        test_cmd_timing(4'd3);
        test_cmd_timing(4'd15);
        test_scan(8'h40, 8'd3, 4);
        test_scan(8'hFF, 8'd2, 3);
        test_scan(8'h77, 8'd0, 2);
        test_trigger(4'd0);
        test_trigger(4'd6);
        test_done_select();
        test_overrun();
        test_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule